// File: doc/BRIEF.md
# Device Configuration Register File with Base Address Decoding

This block holds the 256-byte configuration space of one bus device. Software reaches it through byte, word or dword accesses at a byte offset. Multibyte values are stored and returned least significant byte first. The space holds the following:

- Identity bytes that are loaded from parameters and can never be written.
- A command byte whose two low bits turn address decoding on for I/O space and for memory space.
- Six base address slots. Each slot's window size (a power of two, or zero for an absent slot) and its address space are fixed by parameters.

A dword write to a present slot is not stored as given. The bits below the window size are cleared and the space indicator is forced into bit 0. From the stored slots and the command byte the block keeps a registered copy of every slot's window base, with a flag that says whether the window may be used. Rules reject a zero base, a window that wraps, an I/O window that reaches past 64 KiB, and a memory window that ends on the very last address. A probe port compares an incoming address of a given space against all usable windows and reports a hit and the slot index.

Top module: `cfg_space`

## Requirements
- R1: After reset, offsets 0x00–0x01 hold VENDOR_ID, 0x02–0x03 hold DEVICE_ID, 0x08 holds REV_ID, 0x09–0x0B hold CLASS_CODE, 0x0E holds HDR_TYPE and 0x3D holds IRQ_PIN. All other bytes, including the command byte at 0x04, read 0. No window is valid.
- R2: Bytes 0x00–0x03, 0x08–0x0B, 0x0E and 0x3D ignore writes. The other byte lanes of the same access are still written.
- R3: `acc_len` selects 0 = byte, 1 = word, 2 or 3 = dword. Lane k carries offset (acc_ofs+k) mod 256 in bits 8k+7:8k, so values are little-endian. On a read, the lanes beyond the access length return 0.
- R4: A dword write whose offset lies in 0x10–0x27 targets slot n = (offset−0x10)>>2. If that slot has a nonzero size, the 4 bytes at 0x10+4n store (data & ~(size−1)) | t, where t = 1 for I/O and 0 for memory.
- R5: A write to a slot of size 0, or any write shorter than a dword, is stored byte by byte without masking.
- R6: Command bit 0 is required for any I/O window to be valid, and command bit 1 for any memory window.
- R7: An I/O window is invalid when its masked base is 0, when base+size−1 wraps, or when base+size−1 ≥ 0x10000.
- R8: A memory window is invalid when its masked base is 0, when it wraps, or when base+size−1 = 0xFFFFFFFF.
- R9: `bar_base` (slot n in bits 32n+31:32n, the stored value with the size bits cleared) and `bar_valid` change on the clock edge that follows the write that altered their inputs.
- R10: `hit` is 1 exactly when the probe address lies in [base, base+size−1] of a valid window whose space matches `probe_is_io`.
- R11: When several windows match, `hit_idx` names the lowest slot index. With no hit, `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current access |
| acc_ofs | input | 8 | Byte offset of the access |
| acc_len | input | 2 | Access length code |
| wdata | input | 32 | Write data, lane 0 in the low byte |
| rdata | output | 32 | Read data for the current offset and length (combinational) |
| probe_addr | input | 32 | Address to compare against the windows |
| probe_is_io | input | 1 | 1 = the probe is an I/O address, 0 = a memory address |
| bar_base | output | 192 | Decoded base of each slot |
| bar_valid | output | 6 | Per-slot window-usable flag |
| hit | output | 1 | The probe falls in a valid window |
| hit_idx | output | 3 | Index of the matching slot |

## Verification
The hardest states to reach are the window edges. These are an I/O window that ends exactly at 0xFFFF against one that starts at 0x10000, and a memory window whose last byte is 0xFFFFFFFF against one that ends a page lower. They can only be reached by programming a slot through the masking write path and then enabling the matching command bit. The bench therefore writes each edge base through dword writes and checks validity one cycle after the write, never earlier. Priority between overlapping windows is reached by placing two memory slots on the same base, then moving the lower one away and probing again.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int NUM_BAR = 6;
  localparam int IDX_W = $clog2(NUM_BAR);
  localparam int NUM_RO = 10;
  localparam logic [7:0] CMD_OFS = 8'h04;
  localparam logic [7:0] BAR_FIRST_OFS = 8'h10;
  localparam logic [7:0] BAR_END_OFS = BAR_FIRST_OFS + 8'(NUM_BAR * 4);

  function automatic logic byte_is_ro(input logic [7:0] ofs);
    case (ofs)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0E, 8'h3D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] len_bytes(input logic [1:0] len);
    case (len)
      2'd0: return 3'd1;
      2'd1: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] bar_store_value(input logic [31:0] data,
                                                  input logic [31:0] size,
                                                  input logic is_io);
    return (data & ~(size - 32'd1)) | {31'd0, is_io};
  endfunction

  function automatic logic window_ok(input logic [31:0] base,
                                     input logic [31:0] size,
                                     input logic is_io);
    logic [32:0] last;
    logic ok;
    last = {1'b0, base} + {1'b0, size} - 33'd1;
    ok = (base != 32'd0) && !last[32] && (last[31:0] > base);
    if (is_io) ok = ok && (last < 33'h10000);
    else ok = ok && (last[31:0] != 32'hFFFF_FFFF);
    return ok;
  endfunction

  function automatic logic in_window(input logic [31:0] probe,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (probe >= base) && ((probe - base) < size);
  endfunction
endpackage

// File: rtl/cfgsp_store.sv
module cfgsp_store
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0,
  parameter logic [7:0] REV_ID = 8'h0,
  parameter logic [23:0] CLASS_CODE = 24'h0,
  parameter logic [7:0] HDR_TYPE = 8'h0,
  parameter logic [7:0] IRQ_PIN = 8'h0,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BAR-1:0] BAR_IO = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [7:0] acc_ofs,
  input  logic [1:0] acc_len,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [7:0] cmd_byte,
  output logic [NUM_BAR*32-1:0] bar_raw,
  output logic [NUM_RO*8-1:0] id_bytes
);
  logic [7:0] mem [256];
  logic [7:0] lane_ofs [4];
  logic [3:0] lane_en;
  logic [7:0] rel_ofs;
  logic [IDX_W-1:0] slot_idx;
  logic slot_range;
  logic [31:0] slot_size;
  logic slot_io;
  logic slot_path;
  logic [31:0] slot_word;
  logic [7:0] slot_ofs;

  function automatic logic [7:0] init_byte(input int k);
    case (k)
      0: return VENDOR_ID[7:0];
      1: return VENDOR_ID[15:8];
      2: return DEVICE_ID[7:0];
      3: return DEVICE_ID[15:8];
      8: return REV_ID;
      9: return CLASS_CODE[7:0];
      10: return CLASS_CODE[15:8];
      11: return CLASS_CODE[23:16];
      14: return HDR_TYPE;
      61: return IRQ_PIN;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      lane_ofs[j] = acc_ofs + 8'(j);
      lane_en[j] = (3'(j) < len_bytes(acc_len));
    end
  end

  always_comb begin
    rel_ofs = acc_ofs - BAR_FIRST_OFS;
    slot_idx = rel_ofs[IDX_W+1:2];
    slot_range = (acc_ofs >= BAR_FIRST_OFS) && (acc_ofs < BAR_END_OFS);
    slot_size = 32'd0;
    slot_io = 1'b0;
    for (int k = 0; k < NUM_BAR; k++) begin
      if (slot_range && (slot_idx == IDX_W'(k))) begin
        slot_size = BAR_SIZES[k*32 +: 32];
        slot_io = BAR_IO[k];
      end
    end
    slot_path = acc_len[1] && slot_range && (slot_size != 32'd0);
    slot_word = bar_store_value(wdata, slot_size, slot_io);
    slot_ofs = BAR_FIRST_OFS + {rel_ofs[7:2], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] <= init_byte(k);
    end else if (wr_en) begin
      if (slot_path) begin
        for (int j = 0; j < 4; j++) mem[slot_ofs + 8'(j)] <= slot_word[8*j +: 8];
      end else begin
        for (int j = 0; j < 4; j++) begin
          if (lane_en[j] && !byte_is_ro(lane_ofs[j])) mem[lane_ofs[j]] <= wdata[8*j +: 8];
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < 4; j++) rdata[8*j +: 8] = lane_en[j] ? mem[lane_ofs[j]] : 8'h00;
  end

  assign cmd_byte = mem[CMD_OFS];
  assign id_bytes = {mem[8'h3D], mem[8'h0E], mem[8'h0B], mem[8'h0A], mem[8'h09],
                     mem[8'h08], mem[8'h03], mem[8'h02], mem[8'h01], mem[8'h00]};

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_raw
    localparam logic [7:0] O = BAR_FIRST_OFS + 8'(4 * i);
    assign bar_raw[i*32 +: 32] = {mem[O + 8'd3], mem[O + 8'd2], mem[O + 8'd1], mem[O]};
  end
endmodule

// File: rtl/cfgsp_bar_decode.sv
module cfgsp_bar_decode
  import cfgsp_pkg::*;
#(
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BAR-1:0] BAR_IO = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [7:0] cmd_byte,
  input  logic [NUM_BAR*32-1:0] bar_raw,
  output logic [NUM_BAR*32-1:0] bar_base,
  output logic [NUM_BAR-1:0] bar_valid
);
  for (genvar i = 0; i < NUM_BAR; i++) begin : g_slot
    localparam logic [31:0] SZ = BAR_SIZES[i*32 +: 32];
    localparam logic IS_IO = BAR_IO[i];
    if (SZ == 32'd0) begin : g_absent
      always_ff @(posedge clk) begin
        bar_base[i*32 +: 32] <= 32'd0;
        bar_valid[i] <= 1'b0;
      end
    end else begin : g_present
      logic [31:0] base_d;
      logic space_on;
      assign base_d = bar_raw[i*32 +: 32] & ~(SZ - 32'd1);
      assign space_on = IS_IO ? cmd_byte[0] : cmd_byte[1];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bar_base[i*32 +: 32] <= 32'd0;
          bar_valid[i] <= 1'b0;
        end else begin
          bar_base[i*32 +: 32] <= base_d;
          bar_valid[i] <= space_on && window_ok(base_d, SZ, IS_IO);
        end
      end
    end
  end
endmodule

// File: rtl/cfgsp_addr_match.sv
module cfgsp_addr_match
  import cfgsp_pkg::*;
#(
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BAR-1:0] BAR_IO = '0
) (
  input  logic [31:0] probe_addr,
  input  logic probe_is_io,
  input  logic [NUM_BAR*32-1:0] bar_base,
  input  logic [NUM_BAR-1:0] bar_valid,
  output logic hit,
  output logic [IDX_W-1:0] hit_idx
);
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NUM_BAR - 1; i >= 0; i--) begin
      if (bar_valid[i] && (BAR_IO[i] == probe_is_io) &&
          in_window(probe_addr, bar_base[i*32 +: 32], BAR_SIZES[i*32 +: 32])) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hA11C,
  parameter logic [15:0] DEVICE_ID = 16'h0B7E,
  parameter logic [7:0] REV_ID = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h0C0300,
  parameter logic [7:0] HDR_TYPE = 8'h80,
  parameter logic [7:0] IRQ_PIN = 8'h01,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES =
    {32'h0, 32'h4, 32'h0, 32'h100, 32'h1000, 32'h10},
  parameter logic [NUM_BAR-1:0] BAR_IO = 6'b010001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [7:0] acc_ofs,
  input  logic [1:0] acc_len,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] probe_addr,
  input  logic probe_is_io,
  output logic [NUM_BAR*32-1:0] bar_base,
  output logic [NUM_BAR-1:0] bar_valid,
  output logic hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [7:0] cmd_byte;
  logic [NUM_BAR*32-1:0] bar_raw;
  logic [NUM_RO*8-1:0] id_bytes;

  cfgsp_store #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
    .CLASS_CODE(CLASS_CODE), .HDR_TYPE(HDR_TYPE), .IRQ_PIN(IRQ_PIN),
    .BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_ofs(acc_ofs),
    .acc_len(acc_len), .wdata(wdata), .rdata(rdata), .cmd_byte(cmd_byte),
    .bar_raw(bar_raw), .id_bytes(id_bytes)
  );

  cfgsp_bar_decode #(.BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO)) u_decode (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .bar_raw(bar_raw),
    .bar_base(bar_base), .bar_valid(bar_valid)
  );

  cfgsp_addr_match #(.BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO)) u_match (
    .probe_addr(probe_addr), .probe_is_io(probe_is_io), .bar_base(bar_base),
    .bar_valid(bar_valid), .hit(hit), .hit_idx(hit_idx)
  );
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk
  import cfgsp_pkg::*;
#(
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BAR-1:0] BAR_IO = '0
) (
  input logic clk,
  input logic rst_n,
  input logic [7:0] cmd_byte,
  input logic [NUM_RO*8-1:0] id_bytes,
  input logic [NUM_BAR*32-1:0] bar_base,
  input logic [NUM_BAR-1:0] bar_valid,
  input logic hit,
  input logic [IDX_W-1:0] hit_idx,
  input logic probe_is_io
);
  p_id_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(id_bytes));

  p_io_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bar_valid & BAR_IO) != '0) |-> $past(cmd_byte[0]));

  p_mem_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bar_valid & ~BAR_IO) != '0) |-> $past(cmd_byte[1]));

  p_hit_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bar_valid[hit_idx] && (BAR_IO[hit_idx] == probe_is_io)));

  p_nohit_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0));

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_chk
    localparam logic [31:0] SZ = BAR_SIZES[i*32 +: 32];
    if (BAR_IO[i]) begin : g_io
      p_io_below_64k_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid[i] |-> (({1'b0, bar_base[i*32 +: 32]} + {1'b0, SZ}) <= 33'h10000));
    end else begin : g_mem
      p_mem_not_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid[i] |-> (({1'b0, bar_base[i*32 +: 32]} + {1'b0, SZ}) < 33'h1_0000_0000));
    end
    p_base_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bar_valid[i] |-> ((bar_base[i*32 +: 32] != 32'd0) &&
                        ((bar_base[i*32 +: 32] & (SZ - 32'd1)) == 32'd0)));
  end
endmodule

bind cfg_space cfg_space_chk #(.BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .id_bytes(id_bytes),
  .bar_base(bar_base), .bar_valid(bar_valid), .hit(hit), .hit_idx(hit_idx),
  .probe_is_io(probe_is_io)
);

// File: tb/cfg_space_test.sv
module cfg_space_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] acc_ofs = 8'h00;
  logic [1:0] acc_len = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [31:0] probe_addr = 32'd0;
  logic probe_is_io = 1'b0;
  logic [191:0] bar_base;
  logic [5:0] bar_valid;
  logic hit;
  logic [2:0] hit_idx;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_space uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_ofs(acc_ofs), .acc_len(acc_len),
    .wdata(wdata), .rdata(rdata), .probe_addr(probe_addr), .probe_is_io(probe_is_io),
    .bar_base(bar_base), .bar_valid(bar_valid), .hit(hit), .hit_idx(hit_idx)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [1:0] len, input logic [31:0] d);
    @(negedge clk);
    acc_ofs = ofs; acc_len = len; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, input logic [1:0] len, output logic [31:0] d);
    @(negedge clk);
    acc_ofs = ofs; acc_len = len;
    #1 d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic probe(input logic [31:0] a, input logic io, input logic exp_hit,
                       input logic [2:0] exp_idx, input string tag);
    @(negedge clk);
    probe_addr = a; probe_is_io = io;
    #1;
    chk(tag, {31'd0, hit}, {31'd0, exp_hit});
    chk(tag, {29'd0, hit_idx}, {29'd0, exp_idx});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, 2'd2, v); chk("R1 ids", v, 32'h0B7EA11C);
    rd(8'h08, 2'd2, v); chk("R1 class/rev", v, 32'h0C030003);
    rd(8'h0E, 2'd0, v); chk("R1 header", v, 32'h80);
    rd(8'h3D, 2'd0, v); chk("R1 irq pin", v, 32'h01);
    rd(8'h04, 2'd1, v); chk("R1 command", v, 32'h0);
    rd(8'h10, 2'd2, v); chk("R1 slot0", v, 32'h0);
    chk("R1 valid", {26'd0, bar_valid}, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wr(8'h00, 2'd2, 32'hFFFFFFFF);
    rd(8'h00, 2'd2, v); chk("R2 id dword", v, 32'h0B7EA11C);
    wr(8'h0D, 2'd1, 32'h00005A5A);
    rd(8'h0C, 2'd2, v); chk("R2 mixed word", v, 32'h00805A00);
    wr(8'h3C, 2'd2, 32'h44332211);
    rd(8'h3C, 2'd2, v); chk("R2 mixed dword", v, 32'h44330111);
  endtask

  task automatic t_endian();
    logic [31:0] v;
    wr(8'h40, 2'd1, 32'hFFFFBEEF);
    rd(8'h40, 2'd0, v); chk("R3 lane0", v, 32'hEF);
    rd(8'h41, 2'd0, v); chk("R3 lane1", v, 32'hBE);
    wr(8'h43, 2'd0, 32'h00000012);
    rd(8'h40, 2'd3, v); chk("R3 dword", v, 32'h1200BEEF);
    rd(8'h40, 2'd1, v); chk("R3 word upper zero", v, 32'h0000BEEF);
    wr(8'hFF, 2'd1, 32'h0000CDAB);
    rd(8'hFF, 2'd1, v); chk("R3 wrap", v, 32'h00001CAB);
  endtask

  task automatic t_slots();
    logic [31:0] v;
    wr(8'h10, 2'd2, 32'hFFFFFFFF);
    rd(8'h10, 2'd2, v); chk("R4 io mask", v, 32'hFFFFFFF1);
    wr(8'h14, 2'd2, 32'h12345678);
    rd(8'h14, 2'd2, v); chk("R4 mem mask", v, 32'h12345000);
    wr(8'h22, 2'd2, 32'h0000ABCF);
    rd(8'h20, 2'd2, v); chk("R4 io small unaligned", v, 32'h0000ABCD);
    wr(8'h1C, 2'd2, 32'hDEADBEEF);
    rd(8'h1C, 2'd2, v); chk("R5 absent slot", v, 32'hDEADBEEF);
    wr(8'h19, 2'd0, 32'h000000FF);
    rd(8'h18, 2'd2, v); chk("R5 byte write", v, 32'h0000FF00);
  endtask

  task automatic t_io_decode();
    wr(8'h10, 2'd2, 32'h0000C000);
    settle(); chk("R6 io off", {31'd0, bar_valid[0]}, 32'd0);
    wr(8'h04, 2'd1, 32'h00000001);
    chk("R9 not yet", {31'd0, bar_valid[0]}, 32'd0);
    settle();
    chk("R9 valid next", {31'd0, bar_valid[0]}, 32'd1);
    chk("R9 base0", bar_base[31:0], 32'h0000C000);
    chk("R9 base4", bar_base[159:128], 32'h0000ABCC);
    chk("R6 mem off", {31'd0, bar_valid[1]}, 32'd0);
    wr(8'h10, 2'd2, 32'h00000000);
    settle(); chk("R7 zero base", {31'd0, bar_valid[0]}, 32'd0);
    wr(8'h10, 2'd2, 32'h0000FFF0);
    settle(); chk("R7 ends at FFFF", {31'd0, bar_valid[0]}, 32'd1);
    wr(8'h10, 2'd2, 32'h00010000);
    settle(); chk("R7 past 64K", {31'd0, bar_valid[0]}, 32'd0);
  endtask

  task automatic t_mem_decode();
    wr(8'h04, 2'd0, 32'h00000003);
    wr(8'h14, 2'd2, 32'hFFFFF000);
    settle(); chk("R8 top page", {31'd0, bar_valid[1]}, 32'd0);
    wr(8'h14, 2'd2, 32'hFFFFE000);
    settle(); chk("R8 below top", {31'd0, bar_valid[1]}, 32'd1);
    wr(8'h14, 2'd2, 32'h00000FFF);
    settle(); chk("R8 zero base", {31'd0, bar_valid[1]}, 32'd0);
  endtask

  task automatic t_hit();
    wr(8'h14, 2'd2, 32'h80000000);
    wr(8'h18, 2'd2, 32'h80000000);
    wr(8'h10, 2'd2, 32'h0000C000);
    settle();
    probe(32'h80000080, 1'b0, 1'b1, 3'd1, "R11 lowest wins");
    probe(32'h80000FFF, 1'b0, 1'b1, 3'd1, "R10 last byte");
    probe(32'h80001000, 1'b0, 1'b0, 3'd0, "R10 past end");
    probe(32'h80000080, 1'b1, 1'b0, 3'd0, "R10 space mismatch");
    probe(32'h0000C00F, 1'b1, 1'b1, 3'd0, "R10 io hit");
    probe(32'h0000C010, 1'b1, 1'b0, 3'd0, "R10 io miss");
    wr(8'h14, 2'd2, 32'h90000000);
    settle();
    probe(32'h80000010, 1'b0, 1'b1, 3'd2, "R11 next slot");
    wr(8'h04, 2'd0, 32'h00000001);
    settle();
    probe(32'h80000010, 1'b0, 1'b0, 3'd0, "R6 mem disabled");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readonly();
    t_endian();
    t_slots();
    t_io_decode();
    t_mem_decode();
    t_hit();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule